// File: doc/BRIEF.md
# Tracking Converter Counter Controller

This block is the digital half of a servo-style tracking analog-to-digital converter. It keeps an N-bit code that drives an external DAC. An external comparator reports whether the analog input sits above the DAC output. On every cycle where the rate tick is high, the block moves the code one LSB toward the input. Once the code has reached the input, it keeps stepping one LSB up and one LSB down around it. There is no binary search. The time to settle therefore grows with the distance the input has moved and with how fast it moves.

The code saturates at both ends of its range. Each update emits a one-cycle strobe. A small state machine watches the sequence of step directions and raises a lock flag once the loop has begun to dither. The lock state machine has five states:

- `LK_NOHIST`: the state after reset, before any direction has been recorded.
- `LK_HUNT`: unlocked.
- `LK_REV1`: unlocked, with one reversal seen.
- `LK_LOCKED`: locked.
- `LK_SLIP1`: locked, with one repeated direction seen.

Transitions happen only on updates:

- `LK_NOHIST` goes to `LK_HUNT`.
- From `LK_HUNT`, a reversal goes to `LK_REV1` and a repeat stays in `LK_HUNT`.
- From `LK_REV1`, a reversal goes to `LK_LOCKED` and a repeat goes back to `LK_HUNT`.
- From `LK_LOCKED`, a reversal stays in `LK_LOCKED` and a repeat goes to `LK_SLIP1`.
- From `LK_SLIP1`, a reversal goes back to `LK_LOCKED` and a repeat goes to `LK_HUNT`.

Top module: `track_adc_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the code is mid-scale (only the MSB set, 128 for 8 bits), the strobe is low and the lock flag is low.
- R2: On a clock edge with the tick high and the comparator input high (1 = analog input above DAC), a code below all-ones increases by exactly one.
- R3: On a clock edge with the tick high and the comparator input low, a code above zero decreases by exactly one.
- R4: On a clock edge with the tick low, the code and the lock flag keep their values and the strobe is low afterwards, whatever the comparator input.
- R5: With the code at all-ones, an upward update leaves it at all-ones; the code never wraps to zero.
- R6: With the code at zero, a downward update leaves it at zero; the code never wraps to all-ones.
- R7: The strobe is high for exactly the one cycle following each edge at which an update took place, including updates held by saturation.
- R8: Each update's direction is the comparator value. The first update after reset records a direction without comparing it. The lock flag rises on the second of two consecutive updates that each reverse the previous direction.
- R9: While locked, the lock flag falls on the second of two consecutive updates that each repeat the previous direction. A reversal between repeats restarts that count.
- R10: With the comparator modelled as input code greater than DAC code, the code reaches a target D steps away after D updates. It then alternates between target-1 and target, and the lock flag is high two updates after arrival.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Update enable; one update per edge at which it is high |
| above_i | input | 1 | Comparator result, 1 = analog input above DAC output |
| code_o | output | WIDTH | Current code, fed to the DAC |
| upd_o | output | 1 | One-cycle pulse after each update |
| locked_o | output | 1 | Loop lock flag |

## Verification
Each result is due one clock edge after the tick is sampled high: the code, the strobe and the lock flag are all registered once and change together at that edge. The bench raises the tick at a falling edge and samples every output at the following falling edge. Any check that the strobe has dropped again is made one falling edge later. A run of N updates is made by holding the tick high across N rising edges, so each expected code is the start code plus or minus N, limited by saturation. Lock expectations follow the direction sequence counted update by update.

// File: rtl/track_pkg.sv
package track_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef enum logic [2:0] {
        LK_NOHIST = 3'd0,
        LK_HUNT   = 3'd1,
        LK_REV1   = 3'd2,
        LK_LOCKED = 3'd3,
        LK_SLIP1  = 3'd4
    } lock_state_e;

endpackage

// File: rtl/track_step.sv
module track_step
    import track_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  dir_e             dir,
    output logic [WIDTH-1:0] code_o,
    output logic             strobe_o
);
    localparam logic [WIDTH-1:0] CODE_MID = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] CODE_MAX = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] CODE_MIN = {WIDTH{1'b0}};
    localparam logic [WIDTH-1:0] ONE_LSB  = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] code_q, code_d;
    logic             strobe_q;
    logic             at_top, at_bottom;

    assign at_top    = (code_q == CODE_MAX);
    assign at_bottom = (code_q == CODE_MIN);

    always_comb begin
        code_d = code_q;
        if (step_en) begin
            unique case (dir)
                DIR_UP:   if (!at_top)    code_d = code_q + ONE_LSB;
                DIR_DOWN: if (!at_bottom) code_d = code_q - ONE_LSB;
                default:  code_d = code_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= CODE_MID;
            strobe_q <= 1'b0;
        end else begin
            code_q   <= code_d;
            strobe_q <= step_en;
        end
    end

    assign code_o   = code_q;
    assign strobe_o = strobe_q;

    // R2
    a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step_en) && $past(dir) == DIR_UP && $past(code_q) != CODE_MAX)
        |-> (code_q == $past(code_q) + ONE_LSB));

    // R3
    a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step_en) && $past(dir) == DIR_DOWN && $past(code_q) != CODE_MIN)
        |-> (code_q == $past(code_q) - ONE_LSB));

    // R4
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step_en)) |-> ($stable(code_q) && !strobe_q));

    // R5
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(code_q) == CODE_MAX) |-> (code_q != CODE_MIN));

    // R6
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(code_q) == CODE_MIN) |-> (code_q != CODE_MAX));

    // R7
    a_r7_strobe_follows_update: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> $past(step_en));

endmodule

// File: rtl/track_lock_fsm.sv
module track_lock_fsm
    import track_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  dir_e dir,
    output logic locked_o
);
    lock_state_e state_q, state_d;
    dir_e        prev_dir_q;
    logic        reversal;
    logic        locked_q;

    assign reversal = (dir != prev_dir_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= LK_NOHIST;
            prev_dir_q <= DIR_UP;
        end else begin
            state_q <= state_d;
            if (step_en) prev_dir_q <= dir;
        end
    end

    always_comb begin
        state_d = state_q;
        if (step_en) begin
            unique case (state_q)
                LK_NOHIST: state_d = LK_HUNT;
                LK_HUNT:   state_d = reversal ? LK_REV1   : LK_HUNT;
                LK_REV1:   state_d = reversal ? LK_LOCKED : LK_HUNT;
                LK_LOCKED: state_d = reversal ? LK_LOCKED : LK_SLIP1;
                LK_SLIP1:  state_d = reversal ? LK_LOCKED : LK_HUNT;
                default:   state_d = LK_NOHIST;
            endcase
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else begin
            unique case (state_d)
                LK_LOCKED, LK_SLIP1:                 locked_q <= 1'b1;
                LK_NOHIST, LK_HUNT, LK_REV1:         locked_q <= 1'b0;
                default:                             locked_q <= 1'b0;
            endcase
        end
    end

    assign locked_o = locked_q;

    // R8
    a_r8_lock_rises_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_q) |-> ($past(step_en) && $past(reversal)));

    // R9
    a_r9_lock_falls_on_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_q) |-> ($past(step_en) && !$past(reversal)));

    // R4
    a_r4_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step_en)) |-> $stable(locked_q));

endmodule

// File: rtl/track_adc_ctrl.sv
module track_adc_ctrl
    import track_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             above_i,
    output logic [WIDTH-1:0] code_o,
    output logic             upd_o,
    output logic             locked_o
);
    dir_e step_dir;

    assign step_dir = above_i ? DIR_UP : DIR_DOWN;

    track_step #(.WIDTH(WIDTH)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (tick_i),
        .dir      (step_dir),
        .code_o   (code_o),
        .strobe_o (upd_o)
    );

    track_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (tick_i),
        .dir      (step_dir),
        .locked_o (locked_o)
    );

    // R7
    a_r7_strobe_only_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_i)) |-> upd_o);

endmodule

// File: tb/tb_track_adc_ctrl.sv
module tb_track_adc_ctrl;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         force_mode = 1'b1;
    logic         force_val = 1'b0;
    logic [W-1:0] target = '0;
    logic         above;
    logic [W-1:0] code;
    logic         upd;
    logic         locked;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign above = force_mode ? force_val : (target > code);

    track_adc_ctrl #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .above_i(above),
        .code_o(code), .upd_o(upd), .locked_o(locked)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        tick = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic step(input logic dir_up);
        force_mode = 1'b1;
        force_val = dir_up;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 code in reset", code, 128);
        chk("R1 lock in reset", locked, 0);
        do_reset();
        chk("R1 code after reset", code, 128);
        chk("R1 upd after reset", upd, 0);
        chk("R1 lock after reset", locked, 0);
    endtask

    task automatic t_steps();
        do_reset();
        step(1'b1);
        chk("R2 up step", code, 129);
        chk("R7 strobe high", upd, 1);
        @(negedge clk);
        chk("R7 strobe one cycle", upd, 0);
        force_val = 1'b1;
        repeat (5) @(negedge clk);
        chk("R4 hold code", code, 129);
        chk("R4 no strobe", upd, 0);
        force_val = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 hold code down", code, 129);
        step(1'b0);
        chk("R3 down step", code, 128);
        chk("R7 strobe on down", upd, 1);
    endtask

    task automatic t_lock();
        do_reset();
        step(1'b1);
        step(1'b0);
        chk("R8 one reversal no lock", locked, 0);
        step(1'b1);
        chk("R8 second reversal locks", locked, 1);
        repeat (4) @(negedge clk);
        chk("R4 lock held without tick", locked, 1);
        step(1'b1);
        chk("R9 one repeat keeps lock", locked, 1);
        step(1'b0);
        step(1'b0);
        chk("R9 reversal restarts repeat count", locked, 1);
        step(1'b0);
        chk("R9 two repeats unlock", locked, 0);
        do_reset();
        step(1'b1);
        step(1'b0);
        step(1'b0);
        step(1'b1);
        chk("R8 repeat breaks reversal run", locked, 0);
        step(1'b0);
        chk("R8 two reversals after break", locked, 1);
    endtask

    task automatic t_saturate();
        do_reset();
        force_mode = 1'b1;
        force_val = 1'b1;
        run_ticks(130);
        chk("R5 saturate high", code, 255);
        chk("R7 strobe at saturation", upd, 1);
        step(1'b1);
        chk("R5 no wrap", code, 255);
        force_val = 1'b0;
        run_ticks(300);
        chk("R6 saturate low", code, 0);
        step(1'b0);
        chk("R6 no wrap", code, 0);
        chk("R7 strobe held update", upd, 1);
    endtask

    task automatic t_track();
        do_reset();
        force_mode = 1'b0;
        target = 8'd140;
        run_ticks(12);
        chk("R10 reach target", code, 140);
        run_ticks(1);
        chk("R10 dither below", code, 139);
        run_ticks(1);
        chk("R10 dither back", code, 140);
        chk("R10 locked after arrival", locked, 1);
        target = 8'd120;
        run_ticks(1);
        chk("R9 first move still locked", locked, 1);
        run_ticks(19);
        chk("R10 reach new target", code, 120);
        chk("R9 unlocked while slewing", locked, 0);
        force_mode = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_steps();
        t_lock();
        t_saturate();
        t_track();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule